// File: doc/BRIEF.md
# Hot-Swap Card Power Sequencer

This block decides when the backend supply gate drivers of a plug-in card may switch on. Power-up waits for both board-select inputs to be low and the host enable to be high. After that, the block holds the drivers in a ramp state until the monitored rail reports good, then starts a card reset timer. Once that timer expires, the card is signalled as valid.

An over-current trip turns the drivers off at once and latches a fault. The only way out of the latched state is for the host to drop its enable and raise it again. The fault indication releases in the same cycle that the drivers come back on.

All status flags are active-low open-drain signals on the board. Here each one is modelled as an active-high pull-down enable: a 1 means the flag is pulled low. The board-select and host-enable levels pass through a two-flop synchronizer. The trip and power-good indications arrive already synchronous to the clock.

Top module: `hotswap_seq`

## Requirements
- R1: The gate outputs are on only if, at the previous clock edge, the synchronized board-select inputs were both low and the synchronized host enable was high. An input change at these pins reaches the gate outputs three clock edges later.
- R2: When host enable is low, both gate outputs are 0, the reset output `cardRst` is 1, and `healthyPd` and `sigValidPd` are 0.
- R3: While the gates are on (ramp or on state), `ocTrip` high turns the gates off at the next clock edge. At that same edge `faultPd` goes to 1. A trip while the gates are off has no effect.
- R4: After a trip, the gates stay off while host enable stays high. They turn on again only after host enable has been seen low and then high. `faultPd` returns to 0 in the same cycle that the gates turn back on, and never while the gates are off.
- R5: `drvEnPd` equals `gate3En`, and `gate3En` equals `gate5En`, in every cycle.
- R6: `voltSel` = 0 selects `pgRail5` as the monitored rail, and `voltSel` = 1 selects `pgRail3`. In the ramp state, the monitored rail going good moves the block to the on state at the next edge. In the on state, that rail going bad returns the block to the ramp state at the next edge.
- R7: `healthyPd` is 1 exactly when the gates are on and the monitored rail is good.
- R8: `sigValidPd` becomes 1 after the block has spent `RST_CYCLES` consecutive clock edges in the on state (default 8). `cardRst` is always the inverse of `sigValidPd`.
- R9: During and right after reset, the gates are off and every status flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selAN | input | 1 | Board-select A, active low, asynchronous |
| selBN | input | 1 | Board-select B, active low, asynchronous |
| hostEn | input | 1 | Host power enable level, asynchronous |
| voltSel | input | 1 | Static rail select: 0 = 5 V / mixed, 1 = 3.3 V only |
| ocTrip | input | 1 | Over-current trip indication, synchronous |
| pgRail3 | input | 1 | 3.3 V rail above trip level, synchronous |
| pgRail5 | input | 1 | 5 V rail above trip level, synchronous |
| gate3En | output | 1 | 3.3 V high-side gate driver enable |
| gate5En | output | 1 | 5 V high-side gate driver enable |
| drvEnPd | output | 1 | Pull-down enable of the driver-enabled flag |
| faultPd | output | 1 | Pull-down enable of the fault flag |
| healthyPd | output | 1 | Pull-down enable of the healthy flag |
| sigValidPd | output | 1 | Pull-down enable of the signal-valid flag |
| cardRst | output | 1 | Card reset, active high |

## Verification
A wrong controller state shows up at the gate outputs and at `drvEnPd` within one clock edge of the input that exposes it. For a host-enable or board-select change, that is within three edges. A mishandled fault latch appears as `faultPd` disagreeing with the gates at the edge where they turn back on, so the bench compares the two cycle by cycle across a re-enable. A reset timer that is off by a count appears as `sigValidPd` rising early or late relative to the `RST_CYCLES`-edge window that follows entry to the on state.

// File: rtl/hotswap_pkg.sv
`timescale 1ns/1ps
package hotswap_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_RAMP = 2'd1,
    ST_ON   = 2'd2,
    ST_TRIP = 2'd3
  } hsState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic gateOn;    // drivers enabled this cycle
    logic tripSet;   // trip accepted at the coming edge
    logic powerUp;   // OFF -> RAMP at the coming edge
    logic timerRun;  // in ON state, reset timer counts
  } hsStrobe_t;

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end

endmodule

// File: rtl/hs_ctrl.sv
`timescale 1ns/1ps
module hs_ctrl
  import hotswap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      selAN,
  input  logic      selBN,
  input  logic      hostEn,
  input  logic      pgSel,
  input  logic      ocTrip,
  output hsStrobe_t strb
);

  hsState_e state, stateNext;
  logic allowed;
  logic gatesOn;

  assign allowed = !selAN && !selBN && hostEn;
  assign gatesOn = (state == ST_RAMP) || (state == ST_ON);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:  if (allowed) stateNext = ST_RAMP;
      ST_RAMP: begin
        if (ocTrip)        stateNext = ST_TRIP;
        else if (!allowed) stateNext = ST_OFF;
        else if (pgSel)    stateNext = ST_ON;
      end
      ST_ON: begin
        if (ocTrip)        stateNext = ST_TRIP;
        else if (!allowed) stateNext = ST_OFF;
        else if (!pgSel)   stateNext = ST_RAMP;
      end
      ST_TRIP: if (!hostEn) stateNext = ST_OFF;
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strb.gateOn   = gatesOn;
    strb.tripSet  = gatesOn && ocTrip;
    strb.powerUp  = (state == ST_OFF) && allowed;
    strb.timerRun = (state == ST_ON);
  end

  // R1: gates on only after qualifying inputs at the previous edge
  assert_gate_qualified_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.gateOn |-> $past(allowed));

  // R3: accepted trip lands in the tripped state
  assert_trip_latches_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.tripSet |=> (state == ST_TRIP));

  // R4: tripped state held while host enable stays high
  assert_trip_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TRIP && hostEn) |=> (state == ST_TRIP));

endmodule

// File: rtl/hs_datapath.sv
`timescale 1ns/1ps
module hs_datapath
  import hotswap_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  hsStrobe_t strb,
  input  logic      voltSel,
  input  logic      pgRail3,
  input  logic      pgRail5,
  output logic      pgSel,
  output logic      gate3En,
  output logic      gate5En,
  output logic      drvEnPd,
  output logic      faultPd,
  output logic      healthyPd,
  output logic      sigValidPd,
  output logic      cardRst
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] rstCnt;
  logic             timerDone;
  logic             faultLatched;

  assign pgSel = voltSel ? pgRail3 : pgRail5;

  // Card reset timer
  assign timerDone = (rstCnt == CNT_MAX);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rstCnt <= '0;
    else if (!strb.timerRun)          rstCnt <= '0;
    else if (!timerDone)              rstCnt <= rstCnt + 1'b1;
  end

  // Latched breaker fault
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             faultLatched <= 1'b0;
    else if (strb.tripSet) faultLatched <= 1'b1;
    else if (strb.powerUp) faultLatched <= 1'b0;
  end

  assign gate3En    = strb.gateOn;
  assign gate5En    = strb.gateOn;
  assign drvEnPd    = strb.gateOn;
  assign faultPd    = faultLatched;
  assign healthyPd  = strb.gateOn && pgSel;
  assign sigValidPd = strb.timerRun && timerDone && pgSel;
  assign cardRst    = !sigValidPd;

  // R4: fault releases only together with the gates
  assert_fault_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultLatched) |-> strb.gateOn);

  // R8: signal valid implies healthy
  assert_valid_needs_health_R8: assert property (@(posedge clk) disable iff (!rstN)
    sigValidPd |-> healthyPd);

endmodule

// File: rtl/hotswap_seq.sv
`timescale 1ns/1ps
module hotswap_seq
  import hotswap_pkg::*;
#(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic selAN,
  input  logic selBN,
  input  logic hostEn,
  input  logic voltSel,
  input  logic ocTrip,
  input  logic pgRail3,
  input  logic pgRail5,
  output logic gate3En,
  output logic gate5En,
  output logic drvEnPd,
  output logic faultPd,
  output logic healthyPd,
  output logic sigValidPd,
  output logic cardRst
);

  logic [2:0] syncVec;
  hsStrobe_t  strb;
  logic       pgSel;

  hs_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({selAN, selBN, hostEn}),
    .syncOut(syncVec)
  );

  hs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selAN(syncVec[2]), .selBN(syncVec[1]), .hostEn(syncVec[0]),
    .pgSel(pgSel), .ocTrip(ocTrip), .strb(strb)
  );

  hs_datapath #(.RST_CYCLES(RST_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .voltSel(voltSel), .pgRail3(pgRail3), .pgRail5(pgRail5),
    .pgSel(pgSel), .gate3En(gate3En), .gate5En(gate5En),
    .drvEnPd(drvEnPd), .faultPd(faultPd), .healthyPd(healthyPd),
    .sigValidPd(sigValidPd), .cardRst(cardRst)
  );

  // R5: both gates and driver flag move together
  assert_gates_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    (gate3En == gate5En) && (drvEnPd == gate3En));

endmodule

// File: tb/hotswap_seq_tb_top.sv
`timescale 1ns/1ps
module hotswap_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selAN = 1'b1, selBN = 1'b1, hostEn = 1'b0, voltSel = 1'b0;
  logic ocTrip = 1'b0, pgRail3 = 1'b0, pgRail5 = 1'b0;
  logic gate3En, gate5En, drvEnPd, faultPd, healthyPd, sigValidPd, cardRst;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hotswap_seq #(.RST_CYCLES(8)) dut_i (
    .clk(clk), .rstN(rstN), .selAN(selAN), .selBN(selBN), .hostEn(hostEn),
    .voltSel(voltSel), .ocTrip(ocTrip), .pgRail3(pgRail3), .pgRail5(pgRail5),
    .gate3En(gate3En), .gate5En(gate5En), .drvEnPd(drvEnPd), .faultPd(faultPd),
    .healthyPd(healthyPd), .sigValidPd(sigValidPd), .cardRst(cardRst)
  );

  // Vector: [15]selAN [14]selBN [13]hostEn [12]voltSel [11]ocTrip [10]pgRail3
  //         [9]pgRail5 [8:4]wait edges [3:0] expected {gate, fault, healthy, sigValid}
  localparam int NVEC = 19;
  localparam logic [15:0] VEC [NVEC] = '{
    16'b1_1_1_0_0_0_1_00101_0000, // R1 both selects high
    16'b0_1_1_0_0_0_1_00101_0000, // R1 one select high
    16'b0_0_0_0_0_0_1_00101_0000, // R2 enable low
    16'b0_0_1_0_0_0_0_00101_1000, // R6 ramp, rail not good
    16'b0_0_1_0_0_0_1_00100_1010, // R7 healthy, timer running
    16'b0_0_1_0_0_0_1_01100_1011, // R8 timer expired
    16'b0_0_1_0_0_0_0_00011_1000, // R6 rail lost -> ramp
    16'b0_0_1_0_0_0_1_01100_1011, // R8 valid again
    16'b0_0_1_0_1_0_1_00010_0100, // R3 trip
    16'b0_0_1_0_0_0_1_00101_0100, // R4 stays tripped
    16'b0_0_0_0_0_0_1_00101_0100, // R4 enable low, fault held
    16'b0_0_1_0_0_0_1_00101_1010, // R4 re-enable clears fault
    16'b0_0_1_0_0_0_1_01100_1011, // R8
    16'b0_0_1_1_0_0_1_00011_1000, // R6 voltSel=1 watches pgRail3
    16'b0_0_1_1_0_1_1_01100_1011, // R6 pgRail3 good
    16'b0_1_1_1_0_1_1_00101_0000, // R1 select released
    16'b0_1_1_1_1_1_1_00011_0000, // R3 trip while off ignored
    16'b0_0_1_1_0_1_1_01110_1011, // R3 no fault latched, powers up
    16'b0_0_0_1_0_1_1_00101_0000  // R2 enable low
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkCommon();
    check("R5", drvEnPd, gate3En, "drvEnPd vs gate3En");
    check("R5", gate5En, gate3En, "gate5En vs gate3En");
    check("R8", cardRst, !sigValidPd, "cardRst vs sigValidPd");
  endtask

  task automatic stepEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R9 reset state
    pgRail5 = 1'b1; hostEn = 1'b1;
    stepEdges(3);
    check("R9", gate3En, 1'b0, "gate in reset");
    check("R9", faultPd, 1'b0, "fault in reset");
    check("R9", healthyPd, 1'b0, "healthy in reset");
    check("R9", sigValidPd, 1'b0, "valid in reset");
    rstN = 1'b1;
    stepEdges(1);
    check("R9", gate3En, 1'b0, "gate after reset");
    check("R9", faultPd, 1'b0, "fault after reset");

    for (int i = 0; i < NVEC; i++) begin
      selAN = VEC[i][15]; selBN = VEC[i][14]; hostEn = VEC[i][13];
      voltSel = VEC[i][12]; ocTrip = VEC[i][11];
      pgRail3 = VEC[i][10]; pgRail5 = VEC[i][9];
      stepEdges(int'(VEC[i][8:4]));
      check("R1/R3/R4", gate3En, VEC[i][3], $sformatf("vec %0d gate", i));
      check("R3/R4", faultPd, VEC[i][2], $sformatf("vec %0d fault", i));
      check("R7", healthyPd, VEC[i][1], $sformatf("vec %0d healthy", i));
      check("R8", sigValidPd, VEC[i][0], $sformatf("vec %0d valid", i));
      checkCommon();
    end

    // R1 latency: three edges from enable to gate
    hostEn = 1'b1; pgRail3 = 1'b0;
    stepEdges(2);
    check("R1", gate3En, 1'b0, "gate after 2 edges");
    stepEdges(1);
    check("R1", gate3En, 1'b1, "gate after 3 edges");

    // R3 trip in ramp state: one edge
    ocTrip = 1'b1;
    stepEdges(1);
    ocTrip = 1'b0;
    check("R3", gate3En, 1'b0, "gate after trip in ramp");
    check("R3", faultPd, 1'b1, "fault after trip in ramp");

    // R4 fault release cycle-exact with gate turn-on
    hostEn = 1'b0;
    stepEdges(5);
    hostEn = 1'b1;
    for (int e = 1; e <= 5; e++) begin
      stepEdges(1);
      check("R4", faultPd, !gate3En, $sformatf("fault vs gate edge %0d", e));
      check("R4", gate3En, (e >= 3), $sformatf("gate edge %0d", e));
    end

    // R8 exact timer length
    pgRail3 = 1'b1;
    stepEdges(1); // enters ON
    stepEdges(7);
    check("R8", sigValidPd, 1'b0, "valid after 7 edges in on");
    stepEdges(1);
    check("R8", sigValidPd, 1'b1, "valid after 8 edges in on");
    checkCommon();

    finish();
  end

endmodule